// File: doc/BRIEF.md
# Four-Phase Interleaver Address Generator

This block produces the permuted symbol addresses for a duo-binary turbo code whose interleaver is a linear term plus one of four offsets. For index i the address is P(i) = (P0·i + c[i mod 4]) mod N. The offsets are c0 = 1, c1 = floor(N/2) + P1, c2 = P2 and c3 = 1 + floor(N/2) + P3. The block uses no multiplier, no divider and no address table. A running value P0·i mod N is kept by repeated modular addition of P0. Each offset is folded into range once, when the sequence starts. The address is then formed by a second modular adder. Every mod N is a compare against N followed by a conditional subtraction.

A decoder pulses `start` with the block length and the four coefficients on the parameter inputs. These are captured, and one cycle later the address for index 0 appears. Each cycle with `advance` high moves to the next index. `done` marks the last index, N−1. Advancing past it ends the sequence. A new `start` restarts at any time.

Top module: `ilv_addr_gen`

## Requirements
- R1: One cycle after a `start` pulse, `addr_valid` is 1, `done` is 0 and `addr` equals P(0), which is 1. This holds for any N of at least 2.
- R2: For every index i from 0 to N−1, `addr` equals (P0·i + c[i mod 4]) mod N. The phase offsets are c0 = 1, c1 = floor(N/2) + P1, c2 = P2 and c3 = 1 + floor(N/2) + P3. Inputs must satisfy 2 ≤ N and P0, P1, P2, P3 < N.
- R3: While `addr_valid` is 1, `addr` is less than the captured N.
- R4: `done` is 1 exactly while the current index is N−1, and `done` is never 1 while `addr_valid` is 0.
- R5: While valid, a cycle with `advance` low and `start` low leaves `addr`, `done` and `addr_valid` unchanged.
- R6: A cycle with `advance` high while `done` is 1 (and `start` low) ends the sequence: on the next cycle, `addr_valid` and `done` are both 0.
- R7: The parameter inputs are sampled only on a `start` cycle. Changing them in any other cycle has no effect. A `start` in the middle of a sequence takes priority over `advance` and restarts at index 0 with the new parameters.
- R8: A synchronous active-high `rst` clears the block: `addr_valid` is 0, `done` is 0 and `addr` is 0.
- R9: For a parameter set whose formula is a bijection (for example N=24, P0=5, P1=1, P2=1, P3=0), the N addresses of one sequence are all distinct.
- R10: While no sequence is active, `advance` has no effect: `addr_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture parameters and begin at index 0 |
| advance | input | 1 | Move to the next index |
| n_len | input | AW | Block length N |
| p0 | input | AW | Linear coefficient |
| p1 | input | AW | Phase 1 offset coefficient |
| p2 | input | AW | Phase 2 offset coefficient |
| p3 | input | AW | Phase 3 offset coefficient |
| addr | output | AW | Current interleaved address P(i) |
| addr_valid | output | 1 | A sequence is active and `addr` is meaningful |
| done | output | 1 | Current index is N−1 |

## Verification
The bench builds the block with the default 13-bit address width. This width lets the largest length, N = 8191, run together with coefficients of N−1, which drives every conditional subtraction at its extreme. It also runs the smallest lengths, N = 2 and N = 3, where floor(N/2) and the offsets fold around N. Two lengths divisible by four are used with coefficients chosen so that the permutation property can be checked. Random lengths up to about 500, with random stalls and parameter changes in the middle of a sequence, test the hold, ignore and restart rules against a direct-formula model.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned PHASES = 4;

  typedef enum logic [1:0] {
    PH_UNIT      = 2'd0,
    PH_HALF_ONE  = 2'd1,
    PH_TWO       = 2'd2,
    PH_HALF_THR  = 2'd3
  } phase_e;
endpackage

// File: rtl/ilv_modadd.sv
// (a + b) mod m for a, b < m, by one compare and one conditional subtract.
module ilv_modadd #(
  parameter int W = 13
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic [W-1:0] r
);
  localparam int SW = W + 1;

  logic [SW-1:0] raw;
  logic [SW-1:0] lim;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    lim = {1'b0, m};
    r   = (raw >= lim) ? W'(raw - lim) : raw[W-1:0];
  end
endmodule

// File: rtl/ilv_offset_bank.sv
// Folds the four phase offsets into [0, N) and holds them for the sequence.
module ilv_offset_bank
  import ilv_pkg::*;
#(
  parameter int W = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [W-1:0]             n,
  input  logic [W-1:0]             p1,
  input  logic [W-1:0]             p2,
  input  logic [W-1:0]             p3,
  output logic [PHASES-1:0][W-1:0] off_now,
  output logic [PHASES-1:0][W-1:0] off_q
);
  logic [W-1:0]             half;
  logic [W-1:0]             half_inc;
  logic [PHASES-1:0][W-1:0] lhs;
  logic [PHASES-1:0][W-1:0] rhs;

  assign half = n >> 1;

  ilv_modadd #(.W(W)) u_half_inc (
    .a (half),
    .b (W'(1)),
    .m (n),
    .r (half_inc)
  );

  always_comb begin
    lhs[PH_UNIT]     = '0;
    rhs[PH_UNIT]     = W'(1);
    lhs[PH_HALF_ONE] = half;
    rhs[PH_HALF_ONE] = p1;
    lhs[PH_TWO]      = p2;
    rhs[PH_TWO]      = '0;
    lhs[PH_HALF_THR] = half_inc;
    rhs[PH_HALF_THR] = p3;
  end

  generate
    for (genvar k = 0; k < PHASES; k++) begin : g_off
      ilv_modadd #(.W(W)) u_fold (
        .a (lhs[k]),
        .b (rhs[k]),
        .m (n),
        .r (off_now[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       off_q <= '0;
    else if (load) off_q <= off_now;
  end
endmodule

// File: rtl/ilv_lin_acc.sv
// Keeps P0*i mod N, i mod 4 and i; exposes the next-state values.
module ilv_lin_acc
  import ilv_pkg::*;
#(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         step,
  input  logic [W-1:0] n,
  input  logic [W-1:0] p0,
  output logic [W-1:0] lin_d,
  output phase_e       ph_d,
  output logic [W-1:0] idx_d
);
  logic [W-1:0] lin_q;
  logic [W-1:0] lin_inc;
  phase_e       ph_q;
  logic [W-1:0] idx_q;

  ilv_modadd #(.W(W)) u_acc (
    .a (lin_q),
    .b (p0),
    .m (n),
    .r (lin_inc)
  );

  always_comb begin
    lin_d = lin_q;
    ph_d  = ph_q;
    idx_d = idx_q;
    if (start) begin
      lin_d = '0;
      ph_d  = PH_UNIT;
      idx_d = '0;
    end else if (step) begin
      lin_d = lin_inc;
      ph_d  = phase_e'(ph_q + 2'd1);
      idx_d = idx_q + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lin_q <= '0;
      ph_q  <= PH_UNIT;
      idx_q <= '0;
    end else begin
      lin_q <= lin_d;
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          advance,
  input  logic [AW-1:0] n_len,
  input  logic [AW-1:0] p0,
  input  logic [AW-1:0] p1,
  input  logic [AW-1:0] p2,
  input  logic [AW-1:0] p3,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic          done
);
  logic [AW-1:0]             n_q;
  logic [AW-1:0]             p0_q;
  logic [AW-1:0]             n_sel;
  logic                      step;
  logic                      finish;
  logic [AW-1:0]             lin_d;
  phase_e                    ph_d;
  logic [AW-1:0]             idx_d;
  logic [PHASES-1:0][AW-1:0] off_now;
  logic [PHASES-1:0][AW-1:0] off_q;
  logic [AW-1:0]             off_sel;
  logic [AW-1:0]             addr_d;
  logic                      last_d;

  assign step   = !start && addr_valid && advance && !done;
  assign finish = !start && addr_valid && advance && done;
  assign n_sel  = start ? n_len : n_q;

  ilv_lin_acc #(.W(AW)) u_lin (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .step  (step),
    .n     (n_q),
    .p0    (p0_q),
    .lin_d (lin_d),
    .ph_d  (ph_d),
    .idx_d (idx_d)
  );

  ilv_offset_bank #(.W(AW)) u_off (
    .clk     (clk),
    .rst     (rst),
    .load    (start),
    .n       (n_len),
    .p1      (p1),
    .p2      (p2),
    .p3      (p3),
    .off_now (off_now),
    .off_q   (off_q)
  );

  assign off_sel = start ? off_now[ph_d] : off_q[ph_d];
  assign last_d  = (idx_d == n_sel - AW'(1));

  ilv_modadd #(.W(AW)) u_out (
    .a (lin_d),
    .b (off_sel),
    .m (n_sel),
    .r (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q        <= '0;
      p0_q       <= '0;
      addr       <= '0;
      addr_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      if (start) begin
        n_q  <= n_len;
        p0_q <= p0;
      end
      if (start || step) begin
        addr       <= addr_d;
        addr_valid <= 1'b1;
        done       <= last_d;
      end else if (finish) begin
        addr_valid <= 1'b0;
        done       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          advance,
  input logic [AW-1:0] addr,
  input logic          addr_valid,
  input logic          done,
  input logic [AW-1:0] n_q
);
  p_first_addr_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr_valid && !done && addr == AW'(1)));

  p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (addr < n_q));

  p_done_valid_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> addr_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !advance && !start) |=>
      ($stable(addr) && $stable(done) && addr_valid));

  p_end_r6: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && done && advance && !start) |=> (!addr_valid && !done));

  p_step_alive_r2: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !done && advance && !start) |=> addr_valid);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!addr_valid && !done && addr == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!addr_valid && !start) |=> !addr_valid);
endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .advance    (advance),
  .addr       (addr),
  .addr_valid (addr_valid),
  .done       (done),
  .n_q        (n_q)
);

// File: tb/sim_ilv_addr_gen.sv
`timescale 1ns/1ps
module sim_ilv_addr_gen;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          advance = 1'b0;
  logic [AW-1:0] n_len = '0, p0 = '0, p1 = '0, p2 = '0, p3 = '0;
  logic [AW-1:0] addr;
  logic          addr_valid, done;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  ilv_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .advance(advance),
    .n_len(n_len), .p0(p0), .p1(p1), .p2(p2), .p3(p3),
    .addr(addr), .addr_valid(addr_valid), .done(done)
  );

  function automatic int model(int n, int q0, int q1, int q2, int q3, int i);
    longint off;
    case (i % 4)
      0: off = 1;
      1: off = n / 2 + q1;
      2: off = q2;
      default: off = 1 + n / 2 + q3;
    endcase
    return int'((longint'(q0) * i + off) % n);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_params(int n, int q0, int q1, int q2, int q3);
    n_len = AW'(n); p0 = AW'(q0); p1 = AW'(q1); p2 = AW'(q2); p3 = AW'(q3);
  endtask

  task automatic run_set(int n, int q0, int q1, int q2, int q3,
                         bit perm, bit stall, bit scramble);
    bit seen [0:8191];
    int distinct = 0;
    int i = 0;
    bit held = 0;
    for (int k = 0; k < 8192; k++) seen[k] = 0;
    @(negedge clk);
    drive_params(n, q0, q1, q2, q3);
    start = 1'b1; advance = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (i < n) begin
      int e = model(n, q0, q1, q2, q3, i);
      bit adv;
      if (i == 0 && !held) begin
        chk(addr_valid == 1'b1, "R1 valid", int'(addr_valid), 1);
        chk(addr == AW'(1), "R1 first", int'(addr), 1);
      end
      chk(addr_valid == 1'b1, held ? "R5 valid" : "R2 valid", int'(addr_valid), 1);
      chk(int'(addr) == e, held ? "R5 addr" : (scramble ? "R7 addr" : "R2 addr"),
          int'(addr), e);
      chk(done == (i == n - 1), "R4 done", int'(done), int'(i == n - 1));
      if (int'(addr) < n && !seen[addr]) begin
        seen[addr] = 1; distinct++;
      end
      adv = stall ? 1'($urandom % 2) : 1'b1;
      if (scramble)
        drive_params(1 + $urandom % 8191, $urandom % 8191, $urandom % 8191,
                     $urandom % 8191, $urandom % 8191);
      advance = adv;
      @(negedge clk);
      held = !adv;
      if (adv) i++;
    end
    advance = 1'b0;
    chk(addr_valid == 1'b0, "R6 valid", int'(addr_valid), 0);
    chk(done == 1'b0, "R6 done", int'(done), 0);
    if (perm) chk(distinct == n, "R9 distinct", distinct, n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(addr_valid == 1'b0, "R8 valid", int'(addr_valid), 0);
    chk(done == 1'b0, "R8 done", int'(done), 0);
    chk(addr == '0, "R8 addr", int'(addr), 0);
    rst = 1'b0;
    advance = 1'b1;
    repeat (4) @(negedge clk);
    chk(addr_valid == 1'b0, "R10 idle", int'(addr_valid), 0);
    advance = 1'b0;

    run_set(24, 5, 1, 1, 0, 1'b1, 1'b0, 1'b0);
    run_set(48, 7, 1, 0, 1, 1'b1, 1'b1, 1'b0);
    run_set(2, 1, 1, 0, 1, 1'b0, 1'b0, 1'b0);
    run_set(3, 2, 2, 1, 2, 1'b0, 1'b1, 1'b0);
    run_set(8191, 8190, 8190, 8190, 8190, 1'b0, 1'b0, 1'b0);
    run_set(40, 13, 39, 39, 39, 1'b0, 1'b1, 1'b1);

    for (int s = 0; s < 20; s++) begin
      int n = 2 + $urandom % 500;
      run_set(n, $urandom % n, $urandom % n, $urandom % n, $urandom % n,
              1'b0, 1'b1, (s % 3) == 0);
    end

    // R7: restart in mid-sequence with advance also high
    @(negedge clk);
    drive_params(100, 17, 3, 60, 99);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; advance = 1'b1;
    repeat (7) @(negedge clk);
    chk(int'(addr) == model(100, 17, 3, 60, 99, 7), "R2 pre-restart",
        int'(addr), model(100, 17, 3, 60, 99, 7));
    drive_params(77, 30, 70, 5, 76);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk(int'(addr) == model(77, 30, 70, 5, 76, i), "R7 restart",
          int'(addr), model(77, 30, 70, 5, 76, i));
      @(negedge clk);
    end
    advance = 1'b0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule